// File: doc/BRIEF.md
# Steerable Prioritized Interrupt Controller

This block gathers a wide set of active-low, level-sensitive interrupt request lines and turns them into two processor requests: a normal request and a fast request. Each source carries its own configuration entry: an enable, a routing choice between the two requests, and a six-bit priority. The two requests are arbitrated independently of each other. Each one reports the number of its winning source, a valid flag, and an active-low request pin.

Request lines pass through a two-flop synchronizer before arbitration. Each output side runs a balanced comparison tree over the sources routed to it, and the result is registered. Configuration is written one source at a time through a plain write port: an index and an eight-bit word. Vectoring, nesting and bus attachment belong to the surrounding system. There are no streams here, so every pin is a plain control or status signal.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source is disabled, routed to the normal request, and at priority 63. Both request pins are high, both valid flags are 0 and both winner numbers are 0. A winner number reads 0 whenever its valid flag is 0.
- R2: A source is pending while its line is low and pending stops when the line returns high. With no pending source on a side, that side's valid flag is 0.
- R3: Bit 6 of the configuration word selects the route: 1 sends the source to the fast request only, and 0 sends it to the normal request only.
- R4: Among the pending, enabled sources on one side, the one with the numerically smallest priority wins. Priority 0 is the most urgent.
- R5: When priorities are equal, the source with the lower number wins.
- R6: A source whose enable bit (bit 7 of the configuration word) is 0 never wins, whatever its line does.
- R7: Each request pin is low exactly when that side's valid flag is 1.
- R8: The two sides are arbitrated at the same time and independently. A winner on one side does not affect the other side.
- R9: A change on a request line shows at the outputs on the third rising clock edge after it. A configuration write shows on the first rising edge after the edge that stores it.
- R10: The configuration word carries the priority in bits 5:0. A write stores the whole word for the source named by the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n | input | NUM_SRC | Interrupt request lines, active low, level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDW | Source number to write |
| cfg_wdata | input | 8 | {enable, route_fast, priority[5:0]} |
| irq_n | output | 1 | Normal request, active low |
| irq_valid | output | 1 | Normal side has a winner |
| irq_id | output | IDW | Normal side winning source |
| fiq_n | output | 1 | Fast request, active low |
| fiq_valid | output | 1 | Fast side has a winner |
| fiq_id | output | IDW | Fast side winning source |

## Verification
A line change passes two synchronizer flops and then the output register, so it is due on the third rising edge. A configuration write is due on the edge after the one that stores it. The bench drives every input at a falling edge and samples at a falling edge. It counts the rising edges between stimulus and sample. The latency checks sample one edge before the due edge and expect the old result, then sample at the due edge and expect the new one. All other checks wait four cycles so every path has settled.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 6;

  typedef struct packed {
    logic              en;
    logic              fast;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '1;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '1;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int IDW     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDW-1:0]            idx,
  input  src_cfg_t                  wdata,
  output logic [NUM_SRC-1:0]        en_vec,
  output logic [NUM_SRC-1:0]        fast_vec,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  src_cfg_t tbl [NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        tbl[i] <= '{en: 1'b0, fast: 1'b0, prio: PRIO_LEAST};
      end
    end else if (we) begin
      tbl[idx] <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_out
    assign en_vec[i]                   = tbl[i].en;
    assign fast_vec[i]                 = tbl[i].fast;
    assign prio_flat[i*PRIO_W +: PRIO_W] = tbl[i].prio;
  end
endmodule

// File: rtl/pic_prio_tree.sv
module pic_prio_tree #(
  parameter int N   = 128,
  parameter int PW  = 6,
  parameter int IDW = 7
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio_flat,
  output logic            win_valid,
  output logic [IDW-1:0]  win_id
);
  localparam int LVL   = (N < 2) ? 1 : $clog2(N);
  localparam int LEAFS = 1 << LVL;
  localparam int NODES = 2 * LEAFS - 1;

  logic           nv [NODES];
  logic [PW-1:0]  np [NODES];
  logic [IDW-1:0] ni [NODES];

  for (genvar l = 0; l < LEAFS; l++) begin : g_leaf
    if (l < N) begin : g_real
      assign nv[LEAFS-1+l] = cand[l];
      assign np[LEAFS-1+l] = prio_flat[l*PW +: PW];
      assign ni[LEAFS-1+l] = IDW'(l);
    end else begin : g_pad
      assign nv[LEAFS-1+l] = 1'b0;
      assign np[LEAFS-1+l] = '1;
      assign ni[LEAFS-1+l] = '0;
    end
  end

  // The left child always holds the lower source numbers, so the right
  // child wins only on a strictly smaller priority value.
  for (genvar k = 0; k < LEAFS - 1; k++) begin : g_node
    logic take_right;
    assign take_right = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] < np[2*k+1]));
    assign nv[k] = nv[2*k+1] | nv[2*k+2];
    assign np[k] = take_right ? np[2*k+2] : np[2*k+1];
    assign ni[k] = take_right ? ni[2*k+2] : ni[2*k+1];
  end

  assign win_valid = nv[0];
  assign win_id    = ni[0];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC     = 128,
  parameter int SYNC_STAGES = 2,
  localparam int IDW        = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_n,
  input  logic               cfg_we,
  input  logic [IDW-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               irq_n,
  output logic               irq_valid,
  output logic [IDW-1:0]     irq_id,
  output logic               fiq_n,
  output logic               fiq_valid,
  output logic [IDW-1:0]     fiq_id
);
  localparam int SIDES = 2;

  logic [NUM_SRC-1:0]        sync_q;
  logic [NUM_SRC-1:0]        src_lvl;
  logic [NUM_SRC-1:0]        en_vec;
  logic [NUM_SRC-1:0]        fast_vec;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  logic           req_n_q [SIDES];
  logic           val_q   [SIDES];
  logic [IDW-1:0] id_q    [SIDES];

  pic_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_n),
    .q     (sync_q)
  );

  assign src_lvl = ~sync_q;

  pic_cfg_regs #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .idx       (cfg_idx),
    .wdata     (src_cfg_t'(cfg_wdata)),
    .en_vec    (en_vec),
    .fast_vec  (fast_vec),
    .prio_flat (prio_flat)
  );

  // Side 0 is the normal request, side 1 the fast request.
  for (genvar o = 0; o < SIDES; o++) begin : g_side
    logic [NUM_SRC-1:0] cand;
    logic               win_v;
    logic [IDW-1:0]     win_i;

    assign cand = src_lvl & en_vec & ((o == 1) ? fast_vec : ~fast_vec);

    pic_prio_tree #(.N(NUM_SRC), .PW(PRIO_W), .IDW(IDW)) u_tree (
      .cand      (cand),
      .prio_flat (prio_flat),
      .win_valid (win_v),
      .win_id    (win_i)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_n_q[o] <= 1'b1;
        val_q[o]   <= 1'b0;
        id_q[o]    <= '0;
      end else begin
        req_n_q[o] <= ~win_v;
        val_q[o]   <= win_v;
        id_q[o]    <= win_v ? win_i : '0;
      end
    end
  end

  assign irq_n     = req_n_q[0];
  assign irq_valid = val_q[0];
  assign irq_id    = id_q[0];
  assign fiq_n     = req_n_q[1];
  assign fiq_valid = val_q[1];
  assign fiq_id    = id_q[1];
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NUM_SRC = 128,
  parameter int IDW     = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] fast_vec,
  input logic               irq_n,
  input logic               irq_valid,
  input logic [IDW-1:0]     irq_id,
  input logic               fiq_n,
  input logic               fiq_valid,
  input logic [IDW-1:0]     fiq_id
);
  logic [NUM_SRC-1:0] en_q, fast_q, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      fast_q <= '0;
      lvl_q  <= '0;
    end else begin
      en_q   <= en_vec;
      fast_q <= fast_vec;
      lvl_q  <= src_lvl;
    end
  end

  AST_IRQ_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> en_q[irq_id]); // R6
  AST_FIQ_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) fiq_valid |-> en_q[fiq_id]); // R6
  AST_IRQ_ROUTE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> !fast_q[irq_id]); // R3
  AST_FIQ_ROUTE_FAST: assert property (@(posedge clk) disable iff (!rst_n) fiq_valid |-> fast_q[fiq_id]); // R3
  AST_IRQ_SRC_PENDING: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> lvl_q[irq_id]); // R2
  AST_FIQ_SRC_PENDING: assert property (@(posedge clk) disable iff (!rst_n) fiq_valid |-> lvl_q[fiq_id]); // R2
  AST_IRQ_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n) irq_n == !irq_valid); // R7
  AST_FIQ_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n) fiq_n == !fiq_valid); // R7
  AST_IRQ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !irq_valid |-> (irq_id == '0)); // R1
  AST_FIQ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !fiq_valid |-> (fiq_id == '0)); // R1
endmodule

bind prio_irq_ctrl pic_chk #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lvl   (src_lvl),
  .en_vec    (en_vec),
  .fast_vec  (fast_vec),
  .irq_n     (irq_n),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .fiq_n     (fiq_n),
  .fiq_valid (fiq_valid),
  .fiq_id    (fiq_id)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 128;
  localparam int IDW        = 7;
  localparam int WATCHDOG   = 200000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_n;
  logic            cfg_we;
  logic [IDW-1:0]  cfg_idx;
  logic [7:0]      cfg_wdata;
  logic            irq_n, irq_valid, fiq_n, fiq_valid;
  logic [IDW-1:0]  irq_id, fiq_id;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NSRC)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_n     (src_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .irq_n     (irq_n),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .fiq_n     (fiq_n),
    .fiq_valid (fiq_valid),
    .fiq_id    (fiq_id)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Compares both sides; the expected request pin follows from the valid flag.
  task automatic expect_out(string req, bit ev_i, int eid_i, bit ev_f, int eid_f);
    checks++;
    if (irq_valid !== ev_i || int'(irq_id) != eid_i || irq_n !== !ev_i ||
        fiq_valid !== ev_f || int'(fiq_id) != eid_f || fiq_n !== !ev_f) begin
      failures++;
      $display("FAIL %s: actual irq(v=%0b id=%0d n=%0b) fiq(v=%0b id=%0d n=%0b) expected irq(v=%0b id=%0d n=%0b) fiq(v=%0b id=%0d n=%0b)",
               req, irq_valid, irq_id, irq_n, fiq_valid, fiq_id, fiq_n,
               ev_i, eid_i, !ev_i, ev_f, eid_f, !ev_f);
    end
  endtask

  // Word layout: bit 7 enable, bit 6 route to fast, bits 5:0 priority.
  // Called at a falling edge; returns at the falling edge after the storing edge.
  task automatic write_cfg(int idx, bit en, bit fast, int prio);
    cfg_we    = 1'b1;
    cfg_idx   = IDW'(idx);
    cfg_wdata = {en, fast, 6'(prio)};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_out("R1 reset state", 0, 0, 0, 0);
  endtask

  task automatic t_masked_then_enabled();
    src_n[5] = 1'b0;
    settle();
    expect_out("R6 masked source ignored", 0, 0, 0, 0);
    write_cfg(5, 1, 0, 10);
    expect_out("R9 config not yet visible", 0, 0, 0, 0);
    @(negedge clk);
    expect_out("R10 R9 config visible one edge later", 1, 5, 0, 0);
  endtask

  task automatic t_line_latency();
    src_n[5] = 1'b1;
    settle();
    expect_out("R2 released line not pending", 0, 0, 0, 0);
    src_n[5] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    expect_out("R9 line change not visible after two edges", 0, 0, 0, 0);
    @(negedge clk);
    expect_out("R9 line change visible on third edge", 1, 5, 0, 0);
  endtask

  task automatic t_priority();
    write_cfg(20, 1, 0, 3);
    write_cfg(100, 1, 0, 40);
    src_n[20]  = 1'b0;
    src_n[100] = 1'b0;
    settle();
    expect_out("R4 smallest priority value wins", 1, 20, 0, 0);
    write_cfg(7, 1, 0, 3);
    src_n[7] = 1'b0;
    settle();
    expect_out("R5 tie goes to lower number", 1, 7, 0, 0);
  endtask

  task automatic t_routing();
    write_cfg(20, 1, 1, 3);
    settle();
    expect_out("R3 R8 route to fast side", 1, 7, 1, 20);
    write_cfg(7, 1, 1, 3);
    settle();
    expect_out("R8 R5 independent sides", 1, 5, 1, 7);
    write_cfg(7, 0, 1, 3);
    settle();
    expect_out("R6 disabled source drops out", 1, 5, 1, 20);
  endtask

  task automatic t_release_all();
    src_n = '1;
    settle();
    expect_out("R2 R7 all lines released", 0, 0, 0, 0);
  endtask

  task automatic t_index_edges();
    write_cfg(127, 1, 0, 0);
    write_cfg(0, 1, 0, 0);
    src_n[127] = 1'b0;
    settle();
    expect_out("R4 top source number wins alone", 1, 127, 0, 0);
    src_n[0] = 1'b0;
    settle();
    expect_out("R5 source 0 beats 127 at equal priority", 1, 0, 0, 0);
    write_cfg(0, 1, 0, 63);
    settle();
    expect_out("R4 priority 63 loses to priority 0", 1, 127, 0, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    src_n     = '1;
    cfg_we    = 1'b0;
    cfg_idx   = '0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_then_enabled();
    t_line_latency();
    t_priority();
    t_routing();
    t_release_all();
    t_index_edges();
    report();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end
endmodule